// File: doc/BRIEF.md
# Single-Cycle Subset RISC Core

This block is a 32-bit processor core that completes one instruction per clock edge. It supports nine operations: word load and word store, five register-to-register ALU operations (add, subtract, AND, OR, signed set-less-than), branch-on-equal and absolute jump. The core holds a program counter, a 32-entry register file with two combinational read ports and one write port, an ALU, a sign extender, the main decoder, a second decoder for the ALU operation, and next-PC selection. Instruction memory and data memory are word arrays inside the core.

A testbench or bring-up controller holds the core in reset and fills either memory through a preload port. It then releases reset and lets the core run. A debug port reads both memories combinationally at any word index. The current program counter is also visible on a port.

The core has no multi-cycle state machine. Each cycle, the decoder sorts the opcode into one of six instruction classes: ALU, LOAD, STORE, BRANCH, JUMP and NOP. Next-PC selection then chooses one of three transitions: SEQ (PC+4), BRANCH (PC plus the shifted offset) or JUMP (PC upper bits joined to the target field).

Top module: `scc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0, every register clears to 0, and the core writes neither the register file nor data memory. Reset is synchronous.
- R2: Any instruction that is not a taken branch and not a jump advances the PC by exactly 4.
- R3: When opcode bits [31:26] are 0x00, funct bits [5:0] select the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR. The operands are rs (bits [25:21]) and rt (bits [20:16]), and the result is written to rd (bits [15:11]).
- R4: Funct 0x2A writes 1 to rd when rs is less than rt as signed 32-bit numbers, and 0 otherwise.
- R5: Opcode 0x23 forms the address as rs plus the sign-extended bits [15:0]. It writes the data-memory word at that address into rt. The word index is the address bits from bit 2 upward, for as many bits as the memory depth needs.
- R6: Opcode 0x2B stores rt to the address formed as in R5 and leaves every register unchanged.
- R7: Opcode 0x04 compares rs and rt. When they are equal, the next PC is the branch's own address plus the sign-extended bits [15:0] shifted left by 2. Otherwise the next PC is PC+4.
- R8: Opcode 0x02 sets the PC to the current PC's bits [31:28], followed by bits [25:0] of the instruction, followed by two zero bits.
- R9: Register 0 always reads as 0, and writes to it are dropped.
- R10: An opcode outside the set above, or an unlisted funct under opcode 0x00, changes neither the registers nor memory and advances the PC by 4.
- R11: The preload port writes a word at `ld_idx` into the selected memory on a rising edge. The debug port returns both memories' words at `dbg_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_imem_we | input | 1 | Preload write strobe for instruction memory |
| ld_dmem_we | input | 1 | Preload write strobe for data memory (wins over a core store) |
| ld_idx | input | IDX_W (6) | Preload word index |
| ld_data | input | 32 | Preload word |
| dbg_idx | input | IDX_W (6) | Debug read word index |
| dbg_imem_q | output | 32 | Instruction memory word at `dbg_idx` |
| dbg_dmem_q | output | 32 | Data memory word at `dbg_idx` |
| pc_o | output | 32 | Current program counter |

## Verification
The assertions check the following on every cycle:
- the PC clears after reset and steps by 4 on the SEQ transition;
- the PC lands on the shifted offset after a taken branch;
- a jump keeps the PC's upper four bits;
- a store never writes a register;
- set-less-than yields a single bit;
- register 0 reads as zero.

Arithmetic results, signed comparison at the sign boundaries, negative load and store offsets, dropped writes to register 0, and the no-op handling of unknown encodings show up only in the bench's programs. The bench observes these through data-memory contents and the PC after sweeping many operand pairs.

// File: rtl/scc_pkg.sv
package scc_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_JUMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        CL_ALU, CL_LOAD, CL_STORE, CL_BRANCH, CL_JUMP, CL_NOP
    } iclass_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'd0,
        AOP_SUB   = 2'd1,
        AOP_FUNCT = 2'd2
    } aluop_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_NONE
    } alusel_e;

    typedef enum logic [1:0] {
        PCS_SEQ, PCS_BRANCH, PCS_JUMP
    } pcsel_e;

    typedef struct packed {
        logic   reg_dst;
        logic   alu_src;
        logic   mem_to_reg;
        logic   reg_write;
        logic   mem_read;
        logic   mem_write;
        logic   branch;
        logic   jump;
        aluop_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/scc_decode.sv
module scc_decode
    import scc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl,
    output alusel_e    alu_sel
);

    iclass_e cls;

    // Opcode classification
    always_comb begin
        unique case (opcode)
            OPC_RTYPE: cls = CL_ALU;
            OPC_LOAD:  cls = CL_LOAD;
            OPC_STORE: cls = CL_STORE;
            OPC_BEQ:   cls = CL_BRANCH;
            OPC_JUMP:  cls = CL_JUMP;
            default:   cls = CL_NOP;
        endcase
    end

    // Main control and ALU operation decode
    always_comb begin
        ctl        = '0;
        ctl.alu_op = AOP_ADD;
        unique case (cls)
            CL_ALU: begin
                ctl.reg_dst   = 1'b1;
                ctl.reg_write = 1'b1;
                ctl.alu_op    = AOP_FUNCT;
            end
            CL_LOAD: begin
                ctl.alu_src    = 1'b1;
                ctl.mem_to_reg = 1'b1;
                ctl.reg_write  = 1'b1;
                ctl.mem_read   = 1'b1;
            end
            CL_STORE: begin
                ctl.alu_src   = 1'b1;
                ctl.mem_write = 1'b1;
            end
            CL_BRANCH: begin
                ctl.branch = 1'b1;
                ctl.alu_op = AOP_SUB;
            end
            CL_JUMP: ctl.jump = 1'b1;
            default: ctl.alu_op = AOP_ADD;
        endcase

        unique case (ctl.alu_op)
            AOP_ADD: alu_sel = ALU_ADD;
            AOP_SUB: alu_sel = ALU_SUB;
            AOP_FUNCT: begin
                unique case (funct)
                    FN_ADD:  alu_sel = ALU_ADD;
                    FN_SUB:  alu_sel = ALU_SUB;
                    FN_AND:  alu_sel = ALU_AND;
                    FN_OR:   alu_sel = ALU_OR;
                    FN_SLT:  alu_sel = ALU_SLT;
                    default: alu_sel = ALU_NONE;
                endcase
            end
            default: alu_sel = ALU_NONE;
        endcase

        // Unlisted funct: the instruction becomes a no-op
        if (ctl.alu_op == AOP_FUNCT && alu_sel == ALU_NONE) begin
            ctl.reg_write = 1'b0;
        end
    end

endmodule

// File: rtl/scc_alu.sv
module scc_alu
    import scc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alusel_e      sel,
    output logic [W-1:0] y,
    output logic         zero
);

    logic signed [W-1:0] sa;
    logic signed [W-1:0] sb;

    assign sa = a;
    assign sb = b;

    always_comb begin
        unique case (sel)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, (sa < sb)};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/scc_regfile.sv
module scc_regfile #(
    parameter int W       = 32,
    parameter int ENTRIES = 32,
    parameter int AW      = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < ENTRIES; k++) begin
                regs[k] <= '0;
            end
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

    // R9: register 0 observed as zero on both ports
    p_zero_reg_r9: assert property (@(posedge clk) disable iff (rst)
        (ra1 == '0) |-> (rd1 == '0))
        else $error("register 0 read nonzero on port 1");

    p_zero_reg2_r9: assert property (@(posedge clk) disable iff (rst)
        (ra2 == '0) |-> (rd2 == '0))
        else $error("register 0 read nonzero on port 2");

endmodule

// File: rtl/scc_mem.sv
module scc_mem #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata_a = words[raddr_a];
    assign rdata_b = words[raddr_b];

endmodule

// File: rtl/scc_core.sv
module scc_core
    import scc_pkg::*;
#(
    parameter int  IMEM_WORDS = 64,
    parameter int  DMEM_WORDS = 64,
    localparam int IA_W  = $clog2(IMEM_WORDS),
    localparam int DA_W  = $clog2(DMEM_WORDS),
    localparam int IDX_W = (IA_W > DA_W) ? IA_W : DA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_imem_we,
    input  logic             ld_dmem_we,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [31:0]      ld_data,
    input  logic [IDX_W-1:0] dbg_idx,
    output logic [31:0]      dbg_imem_q,
    output logic [31:0]      dbg_dmem_q,
    output logic [31:0]      pc_o
);

    localparam int XLEN    = 32;
    localparam int NREG    = 32;
    localparam int RA_W    = $clog2(NREG);
    localparam int IMM_W   = 16;
    localparam int JT_W    = 26;
    localparam int PC_STEP = 4;

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] instr;
    ctrl_t           ctl;
    alusel_e         alu_sel;
    pcsel_e          pc_sel;

    logic [5:0]      f_opc;
    logic [5:0]      f_funct;
    logic [RA_W-1:0] f_rs;
    logic [RA_W-1:0] f_rt;
    logic [RA_W-1:0] f_rd;
    logic [IMM_W-1:0] f_imm;
    logic [JT_W-1:0] f_jt;

    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic            alu_zero;
    logic [XLEN-1:0] ld_word;
    logic [XLEN-1:0] wb_data;
    logic [RA_W-1:0] wb_addr;
    logic            rf_we;
    logic            st_we;

    logic            dm_we;
    logic [DA_W-1:0] dm_waddr;
    logic [XLEN-1:0] dm_wdata;

    // Instruction fields
    assign f_opc   = instr[31:26];
    assign f_rs    = instr[25:21];
    assign f_rt    = instr[20:16];
    assign f_rd    = instr[15:11];
    assign f_imm   = instr[15:0];
    assign f_funct = instr[5:0];
    assign f_jt    = instr[JT_W-1:0];

    assign imm_ext = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};

    // Instruction memory: written only through the preload port
    scc_mem #(.W(XLEN), .DEPTH(IMEM_WORDS)) u_imem (
        .clk     (clk),
        .we      (ld_imem_we),
        .waddr   (ld_idx[IA_W-1:0]),
        .wdata   (ld_data),
        .raddr_a (pc_q[IA_W+1:2]),
        .rdata_a (instr),
        .raddr_b (dbg_idx[IA_W-1:0]),
        .rdata_b (dbg_imem_q)
    );

    scc_decode u_dec (
        .opcode  (f_opc),
        .funct   (f_funct),
        .ctl     (ctl),
        .alu_sel (alu_sel)
    );

    assign wb_addr = ctl.reg_dst ? f_rd : f_rt;
    assign wb_data = ctl.mem_to_reg ? ld_word : alu_y;
    assign rf_we   = ctl.reg_write && !rst;

    scc_regfile #(.W(XLEN), .ENTRIES(NREG)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (f_rs),
        .ra2 (f_rt),
        .rd1 (rs_val),
        .rd2 (rt_val),
        .we  (rf_we),
        .wa  (wb_addr),
        .wd  (wb_data)
    );

    assign alu_b = ctl.alu_src ? imm_ext : rt_val;

    scc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .sel  (alu_sel),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data memory: preload port has priority over a core store
    assign st_we    = ctl.mem_write && !rst;
    assign dm_we    = ld_dmem_we || st_we;
    assign dm_waddr = ld_dmem_we ? ld_idx[DA_W-1:0] : alu_y[DA_W+1:2];
    assign dm_wdata = ld_dmem_we ? ld_data : rt_val;

    scc_mem #(.W(XLEN), .DEPTH(DMEM_WORDS)) u_dmem (
        .clk     (clk),
        .we      (dm_we),
        .waddr   (dm_waddr),
        .wdata   (dm_wdata),
        .raddr_a (alu_y[DA_W+1:2]),
        .rdata_a (ld_word),
        .raddr_b (dbg_idx[DA_W-1:0]),
        .rdata_b (dbg_dmem_q)
    );

    // Next-PC transition selection
    always_comb begin
        if (ctl.jump) begin
            pc_sel = PCS_JUMP;
        end else if (ctl.branch && alu_zero) begin
            pc_sel = PCS_BRANCH;
        end else begin
            pc_sel = PCS_SEQ;
        end
    end

    always_comb begin
        unique case (pc_sel)
            PCS_SEQ:    pc_next = pc_q + XLEN'(PC_STEP);
            PCS_BRANCH: pc_next = pc_q + {imm_ext[XLEN-3:0], 2'b00};
            PCS_JUMP:   pc_next = {pc_q[XLEN-1:XLEN-4], f_jt, 2'b00};
            default:    pc_next = pc_q + XLEN'(PC_STEP);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign pc_o = pc_q;

    // R1: reset drives the PC to zero
    p_reset_pc_r1: assert property (@(posedge clk)
        rst |=> (pc_q == '0))
        else $error("PC not zero after reset");

    // R2: sequential step
    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctl.jump && !(ctl.branch && alu_zero)) |=> (pc_q == $past(pc_q) + 32'd4))
        else $error("PC did not advance by 4");

    // R7: taken branch lands at own address plus shifted offset
    p_branch_target_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl.branch && alu_zero) |=>
            (pc_q == $past(pc_q) + {$past(imm_ext[XLEN-3:0]), 2'b00}))
        else $error("branch target wrong");

    // R8: jump keeps upper four PC bits and is word aligned
    p_jump_upper_r8: assert property (@(posedge clk) disable iff (rst)
        ctl.jump |=> (pc_q[31:28] == $past(pc_q[31:28]) && pc_q[1:0] == 2'b00))
        else $error("jump target upper bits wrong");

    // R6: a store never writes the register file
    p_store_no_rf_r6: assert property (@(posedge clk) disable iff (rst)
        st_we |-> !rf_we)
        else $error("store wrote a register");

    // R5: load and store never coincide
    p_one_mem_op_r5: assert property (@(posedge clk) disable iff (rst)
        !(ctl.mem_read && ctl.mem_write))
        else $error("read and write asserted together");

    // R4: set-less-than yields a single bit
    p_slt_bit_r4: assert property (@(posedge clk) disable iff (rst)
        (alu_sel == ALU_SLT) |-> (alu_y[XLEN-1:1] == '0))
        else $error("slt result wider than one bit");

endmodule

// File: tb/scc_core_bench.sv
`timescale 1ns/1ps
module scc_core_bench;

    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_imem_we;
    logic        ld_dmem_we;
    logic [5:0]  ld_idx;
    logic [31:0] ld_data;
    logic [5:0]  dbg_idx;
    logic [31:0] dbg_imem_q;
    logic [31:0] dbg_dmem_q;
    logic [31:0] pc_o;

    int n_checks = 0;
    int n_errors = 0;

    logic [31:0] prog [26];

    always #(CLK_NS/2) clk = ~clk;

    scc_core u_scc_core (
        .clk        (clk),
        .rst        (rst),
        .ld_imem_we (ld_imem_we),
        .ld_dmem_we (ld_dmem_we),
        .ld_idx     (ld_idx),
        .ld_data    (ld_data),
        .dbg_idx    (dbg_idx),
        .dbg_imem_q (dbg_imem_q),
        .dbg_dmem_q (dbg_dmem_q),
        .pc_o       (pc_o)
    );

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs,
                                          input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic logic [31:0] sweep_val(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h0000_0005;
            3: return 32'h0000_0010;
            4: return 32'h7FFF_FFFF;
            5: return 32'h8000_0000;
            6: return 32'hFFFF_FFFF;
            default: return 32'h1234_5678;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_d(input int idx, output logic [31:0] q);
        dbg_idx = 6'(idx);
        #1;
        q = dbg_dmem_q;
    endtask

    task automatic run_pair(input logic [31:0] a, input logic [31:0] b, input bit first);
        logic [31:0] q;
        logic [31:0] sent;
        logic [31:0] slt_exp;
        rst = 1'b1;
        for (int w = 0; w < 26; w++) begin
            @(negedge clk);
            ld_imem_we = 1'b1; ld_idx = 6'(w); ld_data = prog[w];
        end
        for (int d = 1; d < 15; d++) begin
            @(negedge clk);
            ld_imem_we = 1'b0; ld_dmem_we = 1'b1; ld_idx = 6'(d);
            case (d)
                1: ld_data = a;
                2: ld_data = b;
                3: ld_data = 32'h1001_0010;
                default: ld_data = 32'hDEAD_0000 | 32'(d);
            endcase
        end
        @(negedge clk);
        ld_dmem_we = 1'b0;
        if (first) begin
            // R11: preload and debug readback of instruction memory
            for (int w = 0; w < 26; w += 5) begin
                dbg_idx = 6'(w);
                #1;
                chk("R11 imem readback", dbg_imem_q, prog[w]);
            end
            read_d(1, q);
            chk("R11 dmem readback", q, a);
        end
        @(negedge clk);
        rst = 1'b0;
        chk("R1 pc after reset", pc_o, 32'd0);
        @(negedge clk);
        chk("R2 pc after first step", pc_o, 32'd4);
        repeat (21) @(negedge clk);
        chk("R7 pc after beq", pc_o, (a == b) ? 32'd96 : 32'd88);
        repeat (10) @(negedge clk);
        chk("R8 pc at jump loop", pc_o, 32'd100);

        slt_exp = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        read_d(4, q);  chk("R3 add", q, a + b);
        read_d(5, q);  chk("R3 sub", q, a - b);
        read_d(6, q);  chk("R3 and", q, a & b);
        read_d(7, q);  chk("R3 or", q, a | b);
        read_d(8, q);  chk("R4 slt", q, slt_exp);
        read_d(9, q);  chk("R9 r0 stays zero", q, 32'd0);
        read_d(10, q); chk("R10 unknown funct no write", q, 32'd0);
        read_d(11, q); chk("R10 unknown opcode no write", q, 32'd0);
        read_d(14, q); chk("R6 store leaves rt intact", q, a + b);
        read_d(3, q);  chk("R5 negative offset address", q, a);
        sent = 32'hDEAD_000C;
        read_d(12, q); chk("R7 fallthrough path", q, (a == b) ? sent : a);
        sent = 32'hDEAD_000D;
        read_d(13, q); chk("R7 taken path", q, (a == b) ? b : sent);
    endtask

    initial begin
        rst = 1'b1; ld_imem_we = 1'b0; ld_dmem_we = 1'b0;
        ld_idx = '0; ld_data = '0; dbg_idx = '0;

        prog[0]  = enc_i(6'h23, 0, 1, 16'd4);      // lw r1
        prog[1]  = enc_i(6'h23, 0, 2, 16'd8);      // lw r2
        prog[2]  = enc_i(6'h23, 0, 11, 16'd12);    // lw r11 (pointer)
        prog[3]  = enc_r(1, 2, 3, 6'h20);          // add
        prog[4]  = enc_r(1, 2, 4, 6'h22);          // sub
        prog[5]  = enc_r(1, 2, 5, 6'h24);          // and
        prog[6]  = enc_r(1, 2, 6, 6'h25);          // or
        prog[7]  = enc_r(1, 2, 7, 6'h2A);          // slt
        prog[8]  = enc_r(1, 2, 0, 6'h20);          // add into r0
        prog[9]  = enc_r(1, 2, 8, 6'h3F);          // unknown funct
        prog[10] = enc_i(6'h08, 1, 9, 16'd5);      // unknown opcode
        prog[11] = enc_i(6'h2B, 0, 3, 16'd16);
        prog[12] = enc_i(6'h2B, 0, 4, 16'd20);
        prog[13] = enc_i(6'h2B, 0, 5, 16'd24);
        prog[14] = enc_i(6'h2B, 0, 6, 16'd28);
        prog[15] = enc_i(6'h2B, 0, 7, 16'd32);
        prog[16] = enc_i(6'h2B, 0, 0, 16'd36);
        prog[17] = enc_i(6'h2B, 0, 8, 16'd40);
        prog[18] = enc_i(6'h2B, 0, 9, 16'd44);
        prog[19] = enc_i(6'h2B, 0, 3, 16'd56);     // r3 again after stores
        prog[20] = enc_i(6'h2B, 11, 1, 16'hFFFC);  // sw r1,-4(r11)
        prog[21] = enc_i(6'h04, 1, 2, 16'd3);      // beq to word 24
        prog[22] = enc_i(6'h2B, 0, 1, 16'd48);
        prog[23] = {6'h02, 26'd25};
        prog[24] = enc_i(6'h2B, 0, 2, 16'd52);
        prog[25] = {6'h02, 26'd25};                // self loop

        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                run_pair(sweep_val(i), sweep_val(j), (i == 0 && j == 0));
            end
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule